// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This block repairs an 8-bit accumulator value after a plain binary addition or subtraction of two packed BCD operands, so that each nibble holds a valid decimal digit again. It receives the raw binary result with three status bits from the arithmetic stage: a subtract marker, the carry out of bit 3 (half-carry) and the carry out of bit 7. It returns the corrected byte and the updated status bits.

The two directions do not mirror each other. After an addition, the unit looks at the flags and also at the digit values: a nibble above 9 triggers a correction. After a subtraction, only the flags decide, and a digit such as 0xA is passed through unchanged. The correction is computed combinationally. One output register stage follows it. A valid strobe on the input loads the stage, and the result appears one clock later with its own valid bit.

Top module: `dec_adjust_unit`

## Requirements
- R1: Addition (sub_in=0): 0x06 is added when half_in=1 or acc_in[3:0] > 9.
- R2: Addition: after the R1 step, 0x60 is added and carry_out is set to 1 when carry_in=1 or bits [8:4] of the 9-bit partial sum exceed 9. Otherwise carry_out is 0.
- R3: Subtraction (sub_in=1): 0x06 is subtracted only when half_in=1, and 0x60 only when carry_in=1. Digit values are not examined, and carry_out equals carry_in.
- R4: acc_out is the corrected value truncated to 8 bits. zero_out is 1 exactly when acc_out is 0x00.
- R5: half_out is 0 for every accepted input.
- R6: sub_out equals the sub_in that was accepted.
- R7: An accepted carry_in=1 always gives carry_out=1.
- R8: After an accepted input (in_valid=1 at a rising edge), the result and out_valid=1 appear one cycle later. out_valid is 0 in the cycle after any edge where in_valid=0.
- R9: While in_valid=0, all data outputs hold their last values, even when the data inputs change.
- R10: A synchronous reset (rst=1) clears out_valid, acc_out and all flag outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for the input operands |
| acc_in | input | 8 | Raw binary result to adjust |
| sub_in | input | 1 | 1 when the previous operation was a subtraction |
| half_in | input | 1 | Carry or borrow out of bit 3 |
| carry_in | input | 1 | Carry or borrow out of bit 7 |
| out_valid | output | 1 | Registered result is new this cycle |
| acc_out | output | 8 | Decimal-corrected byte |
| sub_out | output | 1 | Subtract marker passed through |
| half_out | output | 1 | Half-carry after adjust, always 0 |
| carry_out | output | 1 | Carry after adjust |
| zero_out | output | 1 | Corrected byte is zero |

## Verification
Properties that involve only flags and timing are checked on every cycle: the one-cycle latency of the valid bit, holding the outputs while the strobe is low, the cleared half-carry, the passed-through subtract marker, a carry that is never lost, no carry created on the subtract path, and the zero flag matching the byte. The corrected byte values can only be shown by the bench's scenarios. These cover low-digit and high-digit fixes, overflow past 0xFF, a result that wraps to zero, and the subtract path leaving digits above 9 unchanged.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int NIB_W  = 4;
  localparam int DATA_W = 2 * NIB_W;
  localparam int DIGIT_MAX = 9;
  localparam int STEP = (1 << NIB_W) - (DIGIT_MAX + 1);

  typedef struct packed {
    logic sub;
    logic half;
    logic carry;
    logic zero;
  } dau_flags_t;
endpackage

// File: rtl/dau_low_fix.sv
module dau_low_fix
  import dau_pkg::*;
(
  input  logic [DATA_W-1:0] acc,
  input  logic              sub,
  input  logic              half,
  output logic [DATA_W:0]   part
);
  localparam logic [DATA_W:0]  ADJ = (DATA_W+1)'(STEP);
  localparam logic [NIB_W-1:0] LIM = NIB_W'(DIGIT_MAX);

  logic [DATA_W:0] ext;
  logic            big;
  logic            fix;

  assign ext = {1'b0, acc};
  assign big = acc[NIB_W-1:0] > LIM;

  always_comb begin
    if (sub) begin
      fix  = half;
      part = ext - (fix ? ADJ : '0);
    end else begin
      fix  = half | big;
      part = ext + (fix ? ADJ : '0);
    end
  end
endmodule

// File: rtl/dau_high_fix.sv
module dau_high_fix
  import dau_pkg::*;
(
  input  logic [DATA_W:0]   part,
  input  logic              sub,
  input  logic              carry,
  output logic [DATA_W-1:0] res,
  output logic              carry_o,
  output logic              zero_o
);
  localparam logic [DATA_W-1:0] ADJ = DATA_W'(STEP << NIB_W);
  localparam logic [NIB_W:0]    LIM = (NIB_W+1)'(DIGIT_MAX);

  logic [NIB_W:0] upper;
  logic           fix;

  assign upper = part[DATA_W:NIB_W];

  always_comb begin
    if (sub) begin
      fix     = carry;
      res     = part[DATA_W-1:0] - (fix ? ADJ : '0);
      carry_o = carry;
    end else begin
      fix     = carry | (upper > LIM);
      res     = part[DATA_W-1:0] + (fix ? ADJ : '0);
      carry_o = fix;
    end
  end

  assign zero_o = ~|res;
endmodule

// File: rtl/dau_out_stage.sv
module dau_out_stage
  import dau_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] acc_i,
  input  dau_flags_t        flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] acc_o,
  output dau_flags_t        flags_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      acc_o   <= '0;
      flags_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        acc_o   <= acc_i;
        flags_o <= flags_i;
      end
    end
  end
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
  import dau_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              sub_in,
  input  logic              half_in,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] acc_out,
  output logic              sub_out,
  output logic              half_out,
  output logic              carry_out,
  output logic              zero_out
);
  logic [DATA_W:0]   part;
  logic [DATA_W-1:0] res;
  logic              c_new;
  logic              z_new;
  dau_flags_t        f_new;
  dau_flags_t        f_q;

  dau_low_fix u_low (
    .acc (acc_in),
    .sub (sub_in),
    .half(half_in),
    .part(part)
  );

  dau_high_fix u_high (
    .part   (part),
    .sub    (sub_in),
    .carry  (carry_in),
    .res    (res),
    .carry_o(c_new),
    .zero_o (z_new)
  );

  always_comb begin
    f_new.sub   = sub_in;
    f_new.half  = 1'b0;
    f_new.carry = c_new;
    f_new.zero  = z_new;
  end

  dau_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .valid_i(in_valid),
    .acc_i  (res),
    .flags_i(f_new),
    .valid_o(out_valid),
    .acc_o  (acc_out),
    .flags_o(f_q)
  );

  assign sub_out   = f_q.sub;
  assign half_out  = f_q.half;
  assign carry_out = f_q.carry;
  assign zero_out  = f_q.zero;
endmodule

// File: rtl/dau_checker.sv
module dau_checker
  import dau_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              sub_in,
  input logic              carry_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] acc_out,
  input logic              sub_out,
  input logic              half_out,
  input logic              carry_out,
  input logic              zero_out
);
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc_out) && $stable(carry_out) && $stable(zero_out));

  p_half_clear_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !half_out);

  p_sub_pass_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> sub_out == $past(sub_in));

  p_carry_keep_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && carry_in |=> carry_out);

  p_sub_no_carry_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && sub_in && !carry_in |=> !carry_out);

  p_zero_match_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> zero_out == (acc_out == '0));
endmodule

bind dec_adjust_unit dau_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .sub_in   (sub_in),
  .carry_in (carry_in),
  .out_valid(out_valid),
  .acc_out  (acc_out),
  .sub_out  (sub_out),
  .half_out (half_out),
  .carry_out(carry_out),
  .zero_out (zero_out)
);

// File: tb/dec_adjust_unit_bench.sv
module dec_adjust_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] acc_in = '0;
  logic       sub_in = 1'b0;
  logic       half_in = 1'b0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic [7:0] acc_out;
  logic       sub_out, half_out, carry_out, zero_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dec_adjust_unit u_dec_adjust_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
    .sub_in(sub_in), .half_in(half_in), .carry_in(carry_in),
    .out_valid(out_valid), .acc_out(acc_out), .sub_out(sub_out),
    .half_out(half_out), .carry_out(carry_out), .zero_out(zero_out)
  );

  // {sub,half,carry,0} acc_in expected_acc {carry,zero,0,0}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    24'h015150,  // R1 none
    24'h01A200,  // R1 low digit > 9
    24'h412180,  // R1 half set
    24'h0A5058,  // R2 high digit > 9
    24'h225858,  // R2 carry set
    24'h09A00C,  // R2 R4 wraps to zero
    24'h0FF658,  // R4 truncation
    24'h600668,  // R1 R2 both flags
    24'h83A3A0,  // R3 digit A ignored
    24'hC0F090,  // R3 half
    24'hAA4448,  // R3 carry
    24'hE6600C,  // R3 both to zero
    24'hC03FD0,  // R3 borrow without carry
    24'h800004,  // R4 zero result
    24'h099990   // R1 R2 valid digits
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic h, input logic c, input logic [7:0] a);
    @(negedge clk);
    in_valid = 1'b1; sub_in = s; half_in = h; carry_in = c; acc_in = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk({acc_out, sub_out, half_out, carry_out, zero_out} == '0, "R10 outputs",
        {acc_out, sub_out, half_out, carry_out, zero_out}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      apply(v[23], v[22], v[21], v[19:12]);
      chk(out_valid, "R8 valid", out_valid, 1);
      chk(acc_out == v[11:4], "R1 R2 R3 R4 acc", acc_out, v[11:4]);
      chk(carry_out == v[3], "R2 R3 R7 carry", carry_out, v[3]);
      chk(zero_out == v[2], "R4 zero", zero_out, v[2]);
      chk(half_out == 0, "R5 half", half_out, 0);
      chk(sub_out == v[23], "R6 sub", sub_out, v[23]);
    end

    // R8: valid drops one cycle after the strobe
    apply(1'b0, 1'b0, 1'b0, 8'h37);
    @(negedge clk);
    chk(out_valid == 0, "R8 valid low", out_valid, 0);

    // R9: inputs change without strobe, outputs hold
    acc_in = 8'h9A; carry_in = 1'b1; sub_in = 1'b1; half_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(acc_out == 8'h37, "R9 hold acc", acc_out, 8'h37);
    chk(carry_out == 0 && sub_out == 0, "R9 hold flags", {carry_out, sub_out}, 0);

    // R10: reset after activity
    apply(1'b0, 1'b0, 1'b1, 8'h05);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk({out_valid, acc_out, carry_out} == '0, "R10 reset clears",
        {out_valid, acc_out, carry_out}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule